// File: doc/BRIEF.md
# Serial Port Byte FIFO Pair with Receive Trigger

This block holds the two byte queues of a 16550-style serial port: a transmit queue filled by the host and drained by the serializer, and a receive queue filled by the deserializer and drained by the host. A single write-only control byte steers both. One bit turns queued operation on or off, two self-clearing bits empty either queue, and a two-bit code picks the receive fill level at which a trigger flag rises. Three further bits are accepted and ignored.

Each side offers a push port and a pop port. The read data always shows the oldest stored byte, and each side reports its occupancy. The receive side also reports a sticky overrun flag and the trigger flag, which an interrupt unit outside this block can use. Shift registers, baud timing and interrupt priority stay outside. A clear of the transmit queue therefore never reaches a character that the serializer has already taken.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset both counts are 0, `fifo_mode` is 0, and `rx_trigger` and `rx_overrun` are 0.
- R2: A control write loads `fifo_mode` from bit 0. If bit 0 differs from the current mode, the write empties both queues and clears `rx_overrun`.
- R3: The capacity of each queue is DEPTH (16) bytes when `fifo_mode` is 1 and 1 byte when it is 0. A push to a full queue is dropped and leaves the count unchanged.
- R4: Bytes leave each queue in the order they entered. While the count is non-zero, the read data port shows the oldest byte.
- R5: A control write with bit 2 set empties the transmit queue in the following cycle, and a push or pop in that same cycle is ignored. The receive queue is untouched. The bit does not persist: later writes with bit 2 at 0 clear nothing.
- R6: A control write with bit 1 set empties the receive queue and clears `rx_overrun` in the following cycle. The transmit queue is untouched, and the bit does not persist.
- R7: Control bits 3, 4 and 5 have no effect on counts, contents, mode or flags.
- R8: Control bits 7:6 select the receive trigger level: 00 = 1, 01 = 4, 10 = 8, 11 = 14 bytes. In FIFO mode `rx_trigger` is 1 exactly when `rx_count` is at or above the level. In non-FIFO mode it is 1 exactly when `rx_count` is at least 1.
- R9: A receive push while the receive queue is full drops the byte and sets `rx_overrun`. The flag stays at 1 until a receive clear or a mode change.
- R10: A push and a pop on the same queue in one cycle leave its count unchanged when the queue is neither empty nor full. A pop of an empty queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| tx_push | input | 1 | Host writes a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to queue for transmission |
| tx_pop | input | 1 | Serializer takes the oldest transmit byte |
| tx_rdata | output | 8 | Oldest transmit byte |
| tx_count | output | 5 | Transmit occupancy |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte |
| rx_count | output | 5 | Receive occupancy |
| rx_trigger | output | 1 | Receive occupancy at or above the selected level |
| rx_overrun | output | 1 | Sticky receive overrun |
| fifo_mode | output | 1 | Current queue mode |

## Verification
On every cycle the assertions check the count bounds for each mode, the clear effects one cycle after a clear write, count stability under a simultaneous push and pop, the setting of overrun on a full push, and the trigger limits at empty and at the top level. Byte order, the exact mapping of all four trigger codes, the ignored control bits and the non-persistence of the clear bits need a reference queue model, so only the bench's directed and random scenarios show them.

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          tx_push,
  input  logic [W-1:0]  tx_wdata,
  input  logic          tx_pop,
  output logic [W-1:0]  tx_rdata,
  output logic [CW-1:0] tx_count,
  input  logic          rx_push,
  input  logic [W-1:0]  rx_wdata,
  input  logic          rx_pop,
  output logic [W-1:0]  rx_rdata,
  output logic [CW-1:0] rx_count,
  output logic          rx_trigger,
  output logic          rx_overrun,
  output logic          fifo_mode
);
  logic [W-1:0]  tx_mem [DEPTH];
  logic [W-1:0]  rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [1:0]    lvl;
  logic [CW-1:0] cap, thresh;

  wire mode_flip = ctl_we && (ctl_wdata[0] != fifo_mode);
  wire tx_clr    = (ctl_we && ctl_wdata[2]) || mode_flip;
  wire rx_clr    = (ctl_we && ctl_wdata[1]) || mode_flip;

  assign cap = fifo_mode ? CW'(DEPTH) : CW'(1);

  wire tx_do_push = tx_push && (tx_count < cap);
  wire tx_do_pop  = tx_pop && (tx_count != '0);
  wire rx_do_push = rx_push && (rx_count < cap);
  wire rx_do_pop  = rx_pop && (rx_count != '0);

  assign tx_rdata = tx_mem[tx_rp];
  assign rx_rdata = rx_mem[rx_rp];

  always_comb begin
    case (lvl)
      2'd0:    thresh = CW'(1);
      2'd1:    thresh = CW'(4);
      2'd2:    thresh = CW'(8);
      default: thresh = CW'(14);
    endcase
  end

  assign rx_trigger = fifo_mode ? (rx_count >= thresh) : (rx_count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_mode <= 1'b0;
      lvl       <= 2'd0;
    end else if (ctl_we) begin
      fifo_mode <= ctl_wdata[0];
      lvl       <= ctl_wdata[7:6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_count <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_count <= '0;
    end else begin
      if (tx_do_push) tx_wp <= tx_wp + 1'b1;
      if (tx_do_pop)  tx_rp <= tx_rp + 1'b1;
      if (tx_do_push && !tx_do_pop)      tx_count <= tx_count + 1'b1;
      else if (!tx_do_push && tx_do_pop) tx_count <= tx_count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_count <= '0; rx_overrun <= 1'b0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_count <= '0; rx_overrun <= 1'b0;
    end else begin
      if (rx_push && !rx_do_push) rx_overrun <= 1'b1;
      if (rx_do_push) rx_wp <= rx_wp + 1'b1;
      if (rx_do_pop)  rx_rp <= rx_rp + 1'b1;
      if (rx_do_push && !rx_do_pop)      rx_count <= rx_count + 1'b1;
      else if (!rx_do_push && rx_do_pop) rx_count <= rx_count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!tx_clr && tx_do_push) tx_mem[tx_wp] <= tx_wdata;
    if (!rx_clr && rx_do_push) rx_mem[rx_wp] <= rx_wdata;
  end
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic [7:0]    ctl_wdata,
  input logic          tx_push,
  input logic          tx_pop,
  input logic [CW-1:0] tx_count,
  input logic          rx_push,
  input logic          rx_pop,
  input logic [CW-1:0] rx_count,
  input logic          rx_trigger,
  input logic          rx_overrun,
  input logic          fifo_mode
);
  wire          flip  = ctl_we && (ctl_wdata[0] != fifo_mode);
  wire          txclr = (ctl_we && ctl_wdata[2]) || flip;
  wire          rxclr = (ctl_we && ctl_wdata[1]) || flip;
  wire [CW-1:0] cap   = fifo_mode ? CW'(DEPTH) : CW'(1);

  p_cap_tx_r3: assert property (@(posedge clk) disable iff (!rst_n) tx_count <= cap);
  p_cap_rx_r3: assert property (@(posedge clk) disable iff (!rst_n) rx_count <= cap);

  p_tx_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[2]) |=> tx_count == '0);

  p_rx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[1]) |=> (rx_count == '0 && !rx_overrun));

  p_mode_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> (tx_count == '0 && rx_count == '0 && !rx_overrun));

  p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_count == cap && !rxclr) |=> rx_overrun);

  p_overrun_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !rxclr) |=> rx_overrun);

  p_tx_pushpop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_pop && tx_count != '0 && tx_count < cap && !txclr) |=> $stable(tx_count));

  p_rx_pushpop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_pop && rx_count != '0 && rx_count < cap && !rxclr) |=> $stable(rx_count));

  p_trig_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count == '0 |-> !rx_trigger);

  p_trig_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count >= CW'(14) |-> rx_trigger);
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_uart_fifo_ctl.sv
module test_uart_fifo_ctl;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0] ctl_wdata = 0, tx_wdata = 0, rx_wdata = 0;
  logic [7:0] tx_rdata, rx_rdata;
  logic [4:0] tx_count, rx_count;
  logic rx_trigger, rx_overrun, fifo_mode;

  always #10 clk = ~clk;

  uart_fifo_ctl i_uart_fifo_ctl (.*);

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mtx[$], mrx[$];
  bit m_mode = 0, m_ovr = 0;
  logic [1:0] m_lvl = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lvl_bytes(logic [1:0] l);
    case (l) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  function automatic bit trig_exp();
    return m_mode ? (mrx.size() >= lvl_bytes(m_lvl)) : (mrx.size() >= 1);
  endfunction

  task automatic model_step();
    bit flip, tclr, rclr, popok, pushok;
    int cap;
    flip = ctl_we && (ctl_wdata[0] != m_mode);
    tclr = (ctl_we && ctl_wdata[2]) || flip;
    rclr = (ctl_we && ctl_wdata[1]) || flip;
    cap  = m_mode ? 16 : 1;
    if (tclr) mtx.delete();
    else begin
      popok = tx_pop && mtx.size() > 0; pushok = tx_push && mtx.size() < cap;
      if (popok) void'(mtx.pop_front());
      if (pushok) mtx.push_back(tx_wdata);
    end
    if (rclr) begin mrx.delete(); m_ovr = 0; end
    else begin
      popok = rx_pop && mrx.size() > 0; pushok = rx_push && mrx.size() < cap;
      if (rx_push && !pushok) m_ovr = 1;
      if (popok) void'(mrx.pop_front());
      if (pushok) mrx.push_back(rx_wdata);
    end
    if (ctl_we) begin m_mode = ctl_wdata[0]; m_lvl = ctl_wdata[7:6]; end
  endtask

  task automatic check_all();
    chk("R3 tx_count", tx_count, mtx.size());
    chk("R3 rx_count", rx_count, mrx.size());
    chk("R2 fifo_mode", fifo_mode, m_mode);
    chk("R8 rx_trigger", rx_trigger, trig_exp());
    chk("R9 rx_overrun", rx_overrun, m_ovr);
    if (mtx.size() > 0) chk("R4 tx_rdata", tx_rdata, mtx[0]);
    if (mrx.size() > 0) chk("R4 rx_rdata", rx_rdata, mrx[0]);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    ctl_we = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    check_all();
  endtask

  task automatic wr_ctl(logic [7:0] v);
    ctl_we = 1; ctl_wdata = v; tick();
  endtask

  task automatic rx_in(logic [7:0] d);
    rx_push = 1; rx_wdata = d; tick();
  endtask

  task automatic tx_in(logic [7:0] d);
    tx_push = 1; tx_wdata = d; tick();
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 fifo_mode", fifo_mode, 0);
    chk("R1 rx_trigger", rx_trigger, 0);
    chk("R1 rx_overrun", rx_overrun, 0);

    // R3 non-FIFO capacity 1
    rx_in(8'h11); rx_in(8'h22);
    chk("R3 nonfifo rx_count", rx_count, 1);
    chk("R9 nonfifo overrun", rx_overrun, 1);
    chk("R4 nonfifo first kept", rx_rdata, 8'h11);

    // R2 mode change clears
    wr_ctl(8'h01);
    chk("R2 flip clears rx", rx_count, 0);
    chk("R2 flip clears overrun", rx_overrun, 0);

    // R9 fill receive to 16, then overrun
    for (int i = 0; i < 16; i++) rx_in(8'(8'h40 + i));
    chk("R3 rx full", rx_count, 16);
    chk("R9 no overrun yet", rx_overrun, 0);
    rx_in(8'hEE);
    chk("R9 overrun set", rx_overrun, 1);
    chk("R9 count held", rx_count, 16);
    chk("R4 oldest", rx_rdata, 8'h40);

    // R7 ignored bits
    for (int i = 0; i < 5; i++) tx_in(8'(8'hA0 + i));
    wr_ctl(8'h39);
    chk("R7 tx untouched", tx_count, 5);
    chk("R7 rx untouched", rx_count, 16);
    chk("R7 overrun untouched", rx_overrun, 1);
    chk("R7 mode untouched", fifo_mode, 1);

    // R5 transmit clear, push in same cycle ignored
    tx_push = 1; tx_wdata = 8'h77; wr_ctl(8'h05);
    chk("R5 tx cleared", tx_count, 0);
    chk("R5 rx untouched", rx_count, 16);
    tx_in(8'h5A);
    wr_ctl(8'h01);
    chk("R5 not persistent", tx_count, 1);
    chk("R5 new byte", tx_rdata, 8'h5A);

    // R6 receive clear
    wr_ctl(8'h43);
    chk("R6 rx cleared", rx_count, 0);
    chk("R6 overrun cleared", rx_overrun, 0);
    chk("R6 tx untouched", tx_count, 1);

    // R8 trigger at level 4
    for (int i = 0; i < 3; i++) rx_in(8'(i));
    chk("R8 below 4", rx_trigger, 0);
    rx_in(8'h03);
    chk("R8 at 4", rx_trigger, 1);
    wr_ctl(8'h81);
    chk("R8 level 8 below", rx_trigger, 0);
    wr_ctl(8'h01);
    chk("R8 level 1", rx_trigger, 1);

    // R10 push and pop together
    rx_push = 1; rx_wdata = 8'h99; rx_pop = 1; tick();
    chk("R10 rx count same", rx_count, 4);
    chk("R10 rx order", rx_rdata, 8'h01);
    tx_pop = 1; tick();
    tx_pop = 1; tick();
    chk("R10 empty pop ignored", tx_count, 0);

    // random
    for (int i = 0; i < 4000; i++) begin
      tx_push = ($urandom % 3) != 0; tx_wdata = 8'($urandom);
      tx_pop  = ($urandom % 3) == 0;
      rx_push = ($urandom % 5) < 3;  rx_wdata = 8'($urandom);
      rx_pop  = ($urandom % 4) == 0;
      if ($urandom % 40 == 0) begin
        ctl_we = 1;
        ctl_wdata = 8'($urandom);
        if ($urandom % 4 != 0) ctl_wdata[2:0] = {2'b00, m_mode};
      end
      tick();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule